// File: doc/BRIEF.md
# Camera Link Frame Timing Generator

This block sits in a camera's pixel clock domain and produces the frame valid, line valid and data valid strobes, together with a synthetic 12-bit test image, for a Camera Link base-configuration transmitter. It has two packing modes. In two-tap mode, tap A carries the even pixel and tap B the odd pixel on each clock. In one-tap mode, one pixel goes out per clock on tap A.

Software writes a staging bank through one strobe. The bank holds the image size, the packing mode, the delay from frame valid to the first line, the short gap inside a pair of lines, and the longer gap between pairs. The active copy is taken from the bank only when a frame request is accepted.

Each frame opens with four line valid pulses while frame valid is low. Lines then follow in pairs. In each test pixel, the upper nibble holds the line index and the low byte holds the pixel index within the line.

Top module: `cl_frame_gen`

## Requirements
- R1: After reset, `fval_o`, `lval_o` and `busy_o` are low, both tap buses are zero and `dval_o` is high.
- R2: `dval_o` is high in every cycle after reset.
- R3: A request sampled on `start_i` while idle raises `busy_o` in the next cycle. From that same cycle, `lval_o` pulses four times, each pulse 4 clocks high then 4 clocks low. During these pulses `fval_o` is low and both taps are zero.
- R4: `fval_o` rises in the cycle after the last pulse's low phase. The first `lval_o` rises exactly D clocks later, where D is the frame-valid delay (0 to 256; 0 means both rise together).
- R5: In two-tap mode (`cfg_two_tap_i`=1) a line lasts width/2 clocks. In line cycle k, tap A carries pixel 2k and tap B carries pixel 2k+1. The width must be even.
- R6: In one-tap mode (`cfg_two_tap_i`=0) a line lasts width clocks. Tap A carries pixel k in line cycle k, and tap B stays zero.
- R7: A pixel word is {line index mod 16 in bits [11:8], pixel index mod 256 in bits [7:0]}. The pixel index restarts at 0 on every line, and the line index starts at 0 in every frame.
- R8: Lines are 0-based. After an even-indexed line that is not the last, `lval_o` stays low for the burst gap (1 to 256). After an odd-indexed line that is not the last, it stays low for the pair gap (1 to 4095). `fval_o` stays high through both gaps.
- R9: After the last line, `fval_o` stays high for 16 more clocks and then falls. `busy_o` falls in the same cycle.
- R10: Both taps are zero in every cycle in which `lval_o` is low.
- R11: A request while `busy_o` is high is ignored and is not queued. Once the current frame ends, the block stays idle.
- R12: Writes through `cfg_we_i` take effect only at the next accepted request. The reset values are: two-tap mode, width 16, height 4, delay 16, burst gap 16, pair gap 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame request |
| cfg_we_i | input | 1 | Write strobe for the staging bank |
| cfg_two_tap_i | input | 1 | 1 = two taps, 0 = one tap |
| cfg_width_i | input | 12 | Pixels per line |
| cfg_height_i | input | 12 | Lines per frame (at least 1) |
| cfg_fv_dly_i | input | 9 | Frame valid to first line delay |
| cfg_burst_gap_i | input | 9 | Gap inside a pair of lines |
| cfg_pair_gap_i | input | 12 | Gap between pairs of lines |
| fval_o | output | 1 | Frame valid |
| lval_o | output | 1 | Line valid |
| dval_o | output | 1 | Data valid, constantly high |
| tap_a_o | output | 12 | Tap A pixel data |
| tap_b_o | output | 12 | Tap B pixel data |
| busy_o | output | 1 | Frame in progress |

## Verification
Every result is due one clock after the edge that samples the request. From there on, every strobe and tap value follows a fixed sequence of spans: pre-pulses, delay, lines, gaps and tail. The bench therefore drives the request half a cycle before an edge and reads the outputs at each falling edge. Starting at the first falling edge after the request is taken, it steps through those spans with lengths computed from the configuration, comparing every cycle. It then checks the idle cycle that follows the tail. Ignored requests and staged writes are issued in the middle of a frame, and their absence of effect is read from the same output spans.

// File: rtl/cl_pkg.sv
package cl_pkg;
  localparam int unsigned LO_W  = 8;
  localparam int unsigned HI_W  = 4;
  localparam int unsigned PIX_W = LO_W + HI_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE_HI,
    ST_PRE_LO,
    ST_FDLY,
    ST_LINE,
    ST_GAP,
    ST_TAIL
  } seq_st_e;
endpackage

// File: rtl/cl_cfg_regs.sv
module cl_cfg_regs #(
  parameter int unsigned WID_W       = 12,
  parameter int unsigned HGT_W       = 12,
  parameter int unsigned DLY_W       = 9,
  parameter int unsigned PGAP_W      = 12,
  parameter int unsigned DEF_WIDTH   = 16,
  parameter int unsigned DEF_HEIGHT  = 4,
  parameter int unsigned DEF_FV_DLY  = 16,
  parameter int unsigned DEF_BGAP    = 16,
  parameter int unsigned DEF_PGAP    = 32,
  parameter bit          DEF_TWO_TAP = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              load_i,
  input  logic              two_tap_i,
  input  logic [WID_W-1:0]  width_i,
  input  logic [HGT_W-1:0]  height_i,
  input  logic [DLY_W-1:0]  fv_dly_i,
  input  logic [DLY_W-1:0]  bgap_i,
  input  logic [PGAP_W-1:0] pgap_i,
  output logic              two_tap_o,
  output logic [WID_W-1:0]  width_o,
  output logic [HGT_W-1:0]  height_o,
  output logic [DLY_W-1:0]  fv_dly_o,
  output logic [DLY_W-1:0]  bgap_o,
  output logic [PGAP_W-1:0] pgap_o
);
  logic              stg_two_tap;
  logic [WID_W-1:0]  stg_width;
  logic [HGT_W-1:0]  stg_height;
  logic [DLY_W-1:0]  stg_fv_dly;
  logic [DLY_W-1:0]  stg_bgap;
  logic [PGAP_W-1:0] stg_pgap;

  // staging bank, software side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_two_tap <= DEF_TWO_TAP;
      stg_width   <= WID_W'(DEF_WIDTH);
      stg_height  <= HGT_W'(DEF_HEIGHT);
      stg_fv_dly  <= DLY_W'(DEF_FV_DLY);
      stg_bgap    <= DLY_W'(DEF_BGAP);
      stg_pgap    <= PGAP_W'(DEF_PGAP);
    end else if (we_i) begin
      stg_two_tap <= two_tap_i;
      stg_width   <= width_i;
      stg_height  <= height_i;
      stg_fv_dly  <= fv_dly_i;
      stg_bgap    <= bgap_i;
      stg_pgap    <= pgap_i;
    end
  end

  // active copy, frozen for the whole frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      two_tap_o <= DEF_TWO_TAP;
      width_o   <= WID_W'(DEF_WIDTH);
      height_o  <= HGT_W'(DEF_HEIGHT);
      fv_dly_o  <= DLY_W'(DEF_FV_DLY);
      bgap_o    <= DLY_W'(DEF_BGAP);
      pgap_o    <= PGAP_W'(DEF_PGAP);
    end else if (load_i) begin
      two_tap_o <= stg_two_tap;
      width_o   <= stg_width;
      height_o  <= stg_height;
      fv_dly_o  <= stg_fv_dly;
      bgap_o    <= stg_bgap;
      pgap_o    <= stg_pgap;
    end
  end
endmodule

// File: rtl/cl_timing_fsm.sv
module cl_timing_fsm
  import cl_pkg::*;
#(
  parameter int unsigned WID_W      = 12,
  parameter int unsigned HGT_W      = 12,
  parameter int unsigned DLY_W      = 9,
  parameter int unsigned PGAP_W     = 12,
  parameter int unsigned PRE_PULSES = 4,
  parameter int unsigned PRE_LEN    = 4,
  parameter int unsigned TAIL_LEN   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              two_tap_i,
  input  logic [WID_W-1:0]  width_i,
  input  logic [HGT_W-1:0]  height_i,
  input  logic [DLY_W-1:0]  fv_dly_i,
  input  logic [DLY_W-1:0]  bgap_i,
  input  logic [PGAP_W-1:0] pgap_i,
  output seq_st_e           st_o,
  output logic [HGT_W-1:0]  line_o,
  output logic              accept_o
);
  localparam int unsigned MAX_A = (WID_W > PGAP_W) ? WID_W : PGAP_W;
  localparam int unsigned CNT_W = (MAX_A > DLY_W) ? MAX_A : DLY_W;
  localparam int unsigned PRE_W = $clog2(PRE_PULSES + 1);

  seq_st_e           st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PRE_W-1:0]  pre_q;
  logic [HGT_W-1:0]  line_q;
  logic [WID_W-1:0]  line_len;
  logic [CNT_W-1:0]  line_m1;
  logic [CNT_W-1:0]  dly_m1;
  logic [CNT_W-1:0]  gap_m1;
  logic              cnt_done;
  logic              last_line;

  always_comb begin
    line_len  = two_tap_i ? (width_i >> 1) : width_i;
    line_m1   = CNT_W'(line_len) - CNT_W'(1);
    dly_m1    = CNT_W'(fv_dly_i) - CNT_W'(1);
    // first line of a pair is even-indexed
    gap_m1    = line_q[0] ? (CNT_W'(pgap_i) - CNT_W'(1))
                          : (CNT_W'(bgap_i) - CNT_W'(1));
    cnt_done  = (cnt_q == '0);
    last_line = (line_q == height_i - HGT_W'(1));
  end

  assign accept_o = (st_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      pre_q  <= '0;
      line_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q   <= ST_PRE_HI;
            cnt_q  <= CNT_W'(PRE_LEN - 1);
            pre_q  <= '0;
            line_q <= '0;
          end
        end
        ST_PRE_HI: begin
          if (cnt_done) begin
            st_q  <= ST_PRE_LO;
            cnt_q <= CNT_W'(PRE_LEN - 1);
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_PRE_LO: begin
          if (!cnt_done) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (pre_q != PRE_W'(PRE_PULSES - 1)) begin
            pre_q <= pre_q + PRE_W'(1);
            st_q  <= ST_PRE_HI;
            cnt_q <= CNT_W'(PRE_LEN - 1);
          end else if (fv_dly_i == '0) begin
            st_q  <= ST_LINE;
            cnt_q <= line_m1;
          end else begin
            st_q  <= ST_FDLY;
            cnt_q <= dly_m1;
          end
        end
        ST_FDLY, ST_GAP: begin
          if (cnt_done) begin
            st_q  <= ST_LINE;
            cnt_q <= line_m1;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_LINE: begin
          if (!cnt_done) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (last_line) begin
            st_q  <= ST_TAIL;
            cnt_q <= CNT_W'(TAIL_LEN - 1);
          end else begin
            st_q   <= ST_GAP;
            cnt_q  <= gap_m1;
            line_q <= line_q + HGT_W'(1);
          end
        end
        ST_TAIL: begin
          if (cnt_done) st_q <= ST_IDLE;
          else          cnt_q <= cnt_q - CNT_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o   = st_q;
  assign line_o = line_q;
endmodule

// File: rtl/cl_pattern_gen.sv
module cl_pattern_gen
  import cl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_act_i,
  input  logic             two_tap_i,
  input  logic [HI_W-1:0]  line_tag_i,
  output logic [PIX_W-1:0] tap_a_o,
  output logic [PIX_W-1:0] tap_b_o
);
  logic [LO_W-1:0] pix_q;
  logic [LO_W-1:0] lo_a;
  logic [LO_W-1:0] lo_b;

  // per-line cycle index, wraps naturally
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pix_q <= '0;
    else if (line_act_i) pix_q <= pix_q + LO_W'(1);
    else                 pix_q <= '0;
  end

  always_comb begin
    lo_a = two_tap_i ? {pix_q[LO_W-2:0], 1'b0} : pix_q;
    lo_b = {pix_q[LO_W-2:0], 1'b1};
    tap_a_o = line_act_i ? {line_tag_i, lo_a} : '0;
    tap_b_o = (line_act_i && two_tap_i) ? {line_tag_i, lo_b} : '0;
  end
endmodule

// File: rtl/cl_frame_gen.sv
module cl_frame_gen
  import cl_pkg::*;
#(
  parameter int unsigned WID_W       = 12,
  parameter int unsigned HGT_W       = 12,
  parameter int unsigned DLY_W       = 9,
  parameter int unsigned PGAP_W      = 12,
  parameter int unsigned PRE_PULSES  = 4,
  parameter int unsigned PRE_LEN     = 4,
  parameter int unsigned TAIL_LEN    = 16,
  parameter int unsigned DEF_WIDTH   = 16,
  parameter int unsigned DEF_HEIGHT  = 4,
  parameter int unsigned DEF_FV_DLY  = 16,
  parameter int unsigned DEF_BGAP    = 16,
  parameter int unsigned DEF_PGAP    = 32,
  parameter bit          DEF_TWO_TAP = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cfg_we_i,
  input  logic              cfg_two_tap_i,
  input  logic [WID_W-1:0]  cfg_width_i,
  input  logic [HGT_W-1:0]  cfg_height_i,
  input  logic [DLY_W-1:0]  cfg_fv_dly_i,
  input  logic [DLY_W-1:0]  cfg_burst_gap_i,
  input  logic [PGAP_W-1:0] cfg_pair_gap_i,
  output logic              fval_o,
  output logic              lval_o,
  output logic              dval_o,
  output logic [PIX_W-1:0]  tap_a_o,
  output logic [PIX_W-1:0]  tap_b_o,
  output logic              busy_o
);
  logic              accept;
  logic              act_two_tap;
  logic [WID_W-1:0]  act_width;
  logic [HGT_W-1:0]  act_height;
  logic [DLY_W-1:0]  act_fv_dly;
  logic [DLY_W-1:0]  act_bgap;
  logic [PGAP_W-1:0] act_pgap;
  seq_st_e           st;
  logic [HGT_W-1:0]  line_idx;

  cl_cfg_regs #(
    .WID_W(WID_W), .HGT_W(HGT_W), .DLY_W(DLY_W), .PGAP_W(PGAP_W),
    .DEF_WIDTH(DEF_WIDTH), .DEF_HEIGHT(DEF_HEIGHT), .DEF_FV_DLY(DEF_FV_DLY),
    .DEF_BGAP(DEF_BGAP), .DEF_PGAP(DEF_PGAP), .DEF_TWO_TAP(DEF_TWO_TAP)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .load_i    (accept),
    .two_tap_i (cfg_two_tap_i),
    .width_i   (cfg_width_i),
    .height_i  (cfg_height_i),
    .fv_dly_i  (cfg_fv_dly_i),
    .bgap_i    (cfg_burst_gap_i),
    .pgap_i    (cfg_pair_gap_i),
    .two_tap_o (act_two_tap),
    .width_o   (act_width),
    .height_o  (act_height),
    .fv_dly_o  (act_fv_dly),
    .bgap_o    (act_bgap),
    .pgap_o    (act_pgap)
  );

  cl_timing_fsm #(
    .WID_W(WID_W), .HGT_W(HGT_W), .DLY_W(DLY_W), .PGAP_W(PGAP_W),
    .PRE_PULSES(PRE_PULSES), .PRE_LEN(PRE_LEN), .TAIL_LEN(TAIL_LEN)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .two_tap_i (act_two_tap),
    .width_i   (act_width),
    .height_i  (act_height),
    .fv_dly_i  (act_fv_dly),
    .bgap_i    (act_bgap),
    .pgap_i    (act_pgap),
    .st_o      (st),
    .line_o    (line_idx),
    .accept_o  (accept)
  );

  cl_pattern_gen u_pat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_act_i (st == ST_LINE),
    .two_tap_i  (act_two_tap),
    .line_tag_i (line_idx[HI_W-1:0]),
    .tap_a_o    (tap_a_o),
    .tap_b_o    (tap_b_o)
  );

  assign fval_o = (st == ST_FDLY) || (st == ST_LINE) || (st == ST_GAP) || (st == ST_TAIL);
  assign lval_o = (st == ST_PRE_HI) || (st == ST_LINE);
  assign busy_o = (st != ST_IDLE);
  assign dval_o = 1'b1;
endmodule

// File: rtl/cl_frame_gen_chk.sv
module cl_frame_gen_chk
  import cl_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fval_o,
  input logic             lval_o,
  input logic             busy_o,
  input logic [PIX_W-1:0] tap_a_o,
  input logic [PIX_W-1:0] tap_b_o
);
  AST_TAP_ZERO_NO_LVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lval_o |-> (tap_a_o == '0 && tap_b_o == '0)); // R10

  AST_FVAL_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fval_o |-> busy_o); // R9

  AST_BUSY_ENDS_WITH_FVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fval_o) |-> $fell(busy_o)); // R9

  AST_LVAL_LOW_BEFORE_FVAL_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fval_o) |-> !$past(lval_o)); // R9

  AST_FRAME_OPENS_WITH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (lval_o && !fval_o)); // R3

  AST_LINE_TAG_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lval_o && fval_o && $past(lval_o) && $past(fval_o))
      |-> (tap_a_o[PIX_W-1:LO_W] == $past(tap_a_o[PIX_W-1:LO_W]))); // R7
endmodule

bind cl_frame_gen cl_frame_gen_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .fval_o  (fval_o),
  .lval_o  (lval_o),
  .busy_o  (busy_o),
  .tap_a_o (tap_a_o),
  .tap_b_o (tap_b_o)
);

// File: tb/cl_frame_gen_tb.sv
module cl_frame_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PRE_LEN    = 4;
  localparam int TAIL_LEN   = 16;
  localparam int NVEC       = 4;

  typedef struct packed {
    logic        two_tap;
    logic [11:0] width;
    logic [11:0] height;
    logic [8:0]  fd;
    logic [8:0]  bg;
    logic [11:0] pg;
  } vec_t;

  // two_tap, width, height, fv delay, burst gap, pair gap
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 12'd8,   12'd3,  9'd0,   9'd1,   12'd5},
    '{1'b0, 12'd5,   12'd2,  9'd256, 9'd256, 12'd3},
    '{1'b1, 12'd520, 12'd18, 9'd1,   9'd2,   12'd9},
    '{1'b0, 12'd300, 12'd1,  9'd3,   9'd4,   12'd6}
  };
  localparam vec_t DEF_V = '{1'b1, 12'd16, 12'd4, 9'd16, 9'd16, 12'd32};
  localparam vec_t MID_A = '{1'b1, 12'd8,  12'd4, 9'd2,  9'd3,  12'd4};
  localparam vec_t MID_B = '{1'b0, 12'd6,  12'd2, 9'd5,  9'd2,  12'd7};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic        cfg_two_tap_i = 1'b0;
  logic [11:0] cfg_width_i = '0;
  logic [11:0] cfg_height_i = '0;
  logic [8:0]  cfg_fv_dly_i = '0;
  logic [8:0]  cfg_burst_gap_i = '0;
  logic [11:0] cfg_pair_gap_i = '0;
  logic        fval_o, lval_o, dval_o, busy_o;
  logic [11:0] tap_a_o, tap_b_o;

  int checks = 0;
  int failures = 0;

  cl_frame_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cfg_we_i(cfg_we_i),
    .cfg_two_tap_i(cfg_two_tap_i), .cfg_width_i(cfg_width_i),
    .cfg_height_i(cfg_height_i), .cfg_fv_dly_i(cfg_fv_dly_i),
    .cfg_burst_gap_i(cfg_burst_gap_i), .cfg_pair_gap_i(cfg_pair_gap_i),
    .fval_o(fval_o), .lval_o(lval_o), .dval_o(dval_o),
    .tap_a_o(tap_a_o), .tap_b_o(tap_b_o), .busy_o(busy_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // mode: 0 = taps zero, 1 = two-tap pattern, 2 = one-tap pattern
  task automatic expect_span(int n, bit fv, bit lv, int mode, int line, string req);
    bit ok = 1'b1;
    int act = 0;
    int exp = 0;
    for (int k = 0; k < n; k++) begin
      logic [11:0] ea, eb;
      logic [7:0]  lo;
      ea = '0; eb = '0;
      if (mode == 1) begin
        lo = 8'((2 * k) % 256);
        ea = {4'(line % 16), lo};
        eb = {4'(line % 16), lo | 8'd1};
      end else if (mode == 2) begin
        ea = {4'(line % 16), 8'(k % 256)};
      end
      if (ok && !(fval_o == fv && lval_o == lv && busy_o && dval_o &&
                  tap_a_o == ea && tap_b_o == eb)) begin
        ok  = 1'b0;
        act = int'({fval_o, lval_o, busy_o, dval_o, tap_a_o, tap_b_o});
        exp = int'({fv, lv, 1'b1, 1'b1, ea, eb});
      end
      @(negedge clk_i);
    end
    check(ok, req, $sformatf("span line=%0d len=%0d {fv,lv,busy,dv,a,b}", line, n), act, exp);
  endtask

  task automatic write_cfg(vec_t v);
    cfg_two_tap_i   = v.two_tap;
    cfg_width_i     = v.width;
    cfg_height_i    = v.height;
    cfg_fv_dly_i    = v.fd;
    cfg_burst_gap_i = v.bg;
    cfg_pair_gap_i  = v.pg;
    cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic run_frame(vec_t v);
    int llen;
    int mode;
    llen = v.two_tap ? int'(v.width) / 2 : int'(v.width);
    mode = v.two_tap ? 1 : 2;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int p = 0; p < 4; p++) begin
      expect_span(PRE_LEN, 1'b0, 1'b1, 0, 0, "R3 R10");
      expect_span(PRE_LEN, 1'b0, 1'b0, 0, 0, "R3");
    end
    if (v.fd != 0) expect_span(int'(v.fd), 1'b1, 1'b0, 0, 0, "R4 R10");
    for (int i = 0; i < int'(v.height); i++) begin
      expect_span(llen, 1'b1, 1'b1, mode, i, v.two_tap ? "R5 R7" : "R6 R7");
      if (i < int'(v.height) - 1)
        expect_span((i % 2 == 0) ? int'(v.bg) : int'(v.pg), 1'b1, 1'b0, 0, 0, "R8 R10");
      else
        expect_span(TAIL_LEN, 1'b1, 1'b0, 0, 0, "R9");
    end
    check(!fval_o && !lval_o && !busy_o, "R9", "idle after tail {fv,lv,busy}",
          int'({fval_o, lval_o, busy_o}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(!fval_o && !lval_o && !busy_o && dval_o && tap_a_o == 0 && tap_b_o == 0,
          "R1", "in reset", int'({fval_o, lval_o, busy_o, dval_o}), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!fval_o && !lval_o && !busy_o && tap_a_o == 0 && tap_b_o == 0, "R1",
          "after reset {fv,lv,busy}", int'({fval_o, lval_o, busy_o}), 0);
    check(dval_o, "R2", "dval after reset", int'(dval_o), 1);

    // R12 reset defaults drive the first frame
    run_frame(DEF_V);

    for (int n = 0; n < NVEC; n++) begin
      write_cfg(VECS[n]);
      run_frame(VECS[n]);
    end

    // R11 R12 mid-frame request and staging write
    write_cfg(MID_A);
    fork
      run_frame(MID_A);
      begin
        repeat (30) @(negedge clk_i);
        start_i = 1'b1;
        cfg_two_tap_i = MID_B.two_tap; cfg_width_i = MID_B.width;
        cfg_height_i = MID_B.height;   cfg_fv_dly_i = MID_B.fd;
        cfg_burst_gap_i = MID_B.bg;    cfg_pair_gap_i = MID_B.pg;
        cfg_we_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        cfg_we_i = 1'b0;
      end
    join
    begin
      bit idle_ok = 1'b1;
      for (int k = 0; k < 40; k++) begin
        if (busy_o || fval_o || lval_o) idle_ok = 1'b0;
        @(negedge clk_i);
      end
      check(idle_ok, "R11", "request during busy was queued", int'(!idle_ok), 0);
    end
    // staged values from the mid-frame write apply now
    run_frame(MID_B);
    check(dval_o, "R2", "dval at end", int'(dval_o), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule